// File: doc/BRIEF.md
# PCM Frame Sequencer and Serializer

This block builds one pulse-code-modulation frame per sample period. A slot counter advances on a one-cycle bit tick. It walks through the data slots, which carry the code captured from an external 8-bit converter with the least significant bit first and every bit inverted. It then walks through two fixed framing slots, so a receiver can lock onto frame timing. After the last framing slot the counter enters a terminal state. That state lasts exactly one system clock, and then the counter wraps to slot 0.

The terminal cycle drives three actions. It marks the frame start, it loads the next code into the serializer, and it launches the acquisition for the next frame. Launching the acquisition means opening the sample window for an external track switch and holding the converter's active-low write strobe low for that window. The write strobe then rises, and that edge starts the conversion. The block waits for the converter's active-low done flag, holds the active-low read strobe low for a fixed number of cycles, and latches the converter data on the last of those cycles. A code captured during one frame is transmitted in the frame that follows.

With a 200 Hz tick and the default parameters, a frame is 50 ms long and the sample window is open for 5 ms of it.

Top module: `pcm_frame_seq`

## Requirements
- R1: The slot counter moves up by one on each cycle in which tick_i is high, from slot 0 through slot 9. The serial output and frame_start_o do not change while tick_i stays low.
- R2: In slots 0 to 7, ser_o carries the inverse of bit n of the frame code, where n is the slot number. Bit 0 goes out first.
- R3: ser_o is 1 in slot 8. It is 0 in slot 9 and stays 0 through the terminal cycle.
- R4: A tick in slot 9 produces a terminal cycle. In that cycle frame_start_o is high for exactly one clock, and the next cycle is slot 0.
- R5: In the cycle after the terminal cycle, sample_en_o goes high and adc_wr_no goes low. Both hold until the SAMPLE_TICKS-th tick (default 1). On that tick sample_en_o falls and adc_wr_no rises, and this rising edge starts the conversion.
- R6: After the write strobe rises, adc_rd_no goes low only once adc_done_ni has been low, and it stays low for RD_HOLD cycles (default 2). The data is latched on the last of those cycles. adc_rd_no and adc_wr_no are never low together.
- R7: The code shown in a frame is the most recent completed capture at that frame's terminal cycle. It does not change anywhere in slots 0 to 9.
- R8: If the last read cycle falls in the terminal cycle, the converter data from that cycle goes straight into the frame that begins next.
- R9: A terminal cycle that arrives while a handshake is still unfinished abandons that handshake and opens a new sample window. The next frame then shows the last completed capture.
- R10: Reset clears the counter to slot 0 and the codes to zero. It leaves sample_en_o and frame_start_o low, both strobes high and ser_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle bit-period enable |
| adc_data_i | input | 8 | Converter output code |
| adc_done_ni | input | 1 | Converter conversion-complete flag, active low |
| sample_en_o | output | 1 | Enable for the external sample switch |
| adc_wr_no | output | 1 | Converter start strobe, active low; the conversion starts on its rising edge |
| adc_rd_no | output | 1 | Converter read strobe, active low |
| ser_o | output | 1 | Serial PCM bit |
| frame_start_o | output | 1 | One-cycle marker in the terminal cycle |

## Verification
The finish of a converter read and the frame-boundary load of the serializer can fall in the same clock. In that clock the captured byte must bypass the capture register and enter the new frame directly. The bench provokes this by setting the modelled converter delay so that the last read cycle lands exactly on the terminal cycle. It confirms the hit by seeing adc_rd_no low while frame_start_o is high. It judges the outcome from the following frame, whose serial bits must carry that same byte. In the frame after that, an abandoned handshake must leave the bypassed byte in place.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  typedef enum logic [1:0] {
    CV_IDLE,
    CV_SAMPLE,
    CV_WAIT,
    CV_READ
  } conv_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pcm_slot_ctr.sv
module pcm_slot_ctr #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned FRAME_W = 2,
  localparam int unsigned TERM   = DATA_W + FRAME_W,
  localparam int unsigned SLOT_W = $clog2(TERM + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              term_o
);

  logic [SLOT_W-1:0] slot_q;

  assign term_o = (slot_q == SLOT_W'(TERM));
  assign slot_o = slot_q;

  // terminal slot lasts one clock, independent of tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot_q <= '0;
    else if (term_o)  slot_q <= '0;
    else if (tick_i)  slot_q <= slot_q + SLOT_W'(1);
  end

  assert_slot_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SLOT_W'(TERM));

  assert_slot_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !term_o) |=> (slot_q == $past(slot_q) + SLOT_W'(1)));

  assert_slot_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !term_o) |=> $stable(slot_q));

  assert_slot_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> (slot_q == '0));

endmodule

// File: rtl/pcm_conv_ctrl.sv
module pcm_conv_ctrl
  import pcm_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SAMPLE_TICKS = 1,
  parameter int unsigned RD_HOLD      = 2,
  localparam int unsigned SMP_W       = cnt_width(SAMPLE_TICKS),
  localparam int unsigned RD_W        = cnt_width(RD_HOLD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              launch_i,
  input  logic              done_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              sample_en_o,
  output logic              wr_no,
  output logic              rd_no,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] cap_o
);

  conv_state_e       state_q, state_d;
  logic [SMP_W-1:0]  smp_q, smp_d;
  logic [RD_W-1:0]   rd_q, rd_d;
  logic [DATA_W-1:0] cap_q;

  assign rd_done_o   = (state_q == CV_READ) && (rd_q == '0);
  assign sample_en_o = (state_q == CV_SAMPLE);
  assign wr_no       = (state_q != CV_SAMPLE);
  assign rd_no       = (state_q != CV_READ);
  assign cap_o       = cap_q;

  always_comb begin
    state_d = state_q;
    smp_d   = smp_q;
    rd_d    = rd_q;
    unique case (state_q)
      CV_SAMPLE: if (tick_i) begin
        if (smp_q == '0) state_d = CV_WAIT;
        else             smp_d   = smp_q - SMP_W'(1);
      end
      CV_WAIT: if (!done_ni) begin
        state_d = CV_READ;
        rd_d    = RD_W'(RD_HOLD - 1);
      end
      CV_READ: begin
        if (rd_done_o) state_d = CV_IDLE;
        else           rd_d    = rd_q - RD_W'(1);
      end
      default: ;
    endcase
    // frame boundary pre-empts any unfinished handshake
    if (launch_i) begin
      state_d = CV_SAMPLE;
      smp_d   = SMP_W'(SAMPLE_TICKS - 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CV_IDLE;
      smp_q   <= '0;
      rd_q    <= '0;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      smp_q   <= smp_d;
      rd_q    <= rd_d;
      if (rd_done_o) cap_q <= data_i;
    end
  end

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!wr_no && !rd_no));

  assert_rd_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |-> $past(!done_ni));

  assert_window_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> (sample_en_o && !wr_no));

  assert_wr_rise_closes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> $fell(sample_en_o));

endmodule

// File: rtl/pcm_serializer.sv
module pcm_serializer #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned FRAME_W       = 2,
  parameter logic [FRAME_W-1:0] FRAME_PAT = 2'b01,
  parameter bit          INVERT_DATA   = 1'b1,
  localparam int unsigned TERM         = DATA_W + FRAME_W,
  localparam int unsigned SLOT_W       = $clog2(TERM + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] code_i,
  output logic [DATA_W-1:0] code_o,
  output logic              ser_o
);

  logic [DATA_W-1:0] code_q;
  logic [DATA_W-1:0] data_bits;
  logic [TERM:0]     slot_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= '0;
    else if (load_i) code_q <= code_i;
  end

  generate
    if (INVERT_DATA) begin : g_inv
      assign data_bits = ~code_q;
    end else begin : g_pass
      assign data_bits = code_q;
    end
  endgenerate

  // terminal slot repeats the last framing level
  assign slot_bits = {FRAME_PAT[FRAME_W-1], FRAME_PAT, data_bits};
  assign ser_o     = slot_bits[slot_i];
  assign code_o    = code_q;

endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned FRAME_W       = 2,
  parameter logic [FRAME_W-1:0] FRAME_PAT = 2'b01,
  parameter int unsigned SAMPLE_TICKS  = 1,
  parameter int unsigned RD_HOLD       = 2,
  parameter bit          INVERT_DATA   = 1'b1,
  localparam int unsigned TERM         = DATA_W + FRAME_W,
  localparam int unsigned SLOT_W       = $clog2(TERM + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] adc_data_i,
  input  logic              adc_done_ni,
  output logic              sample_en_o,
  output logic              adc_wr_no,
  output logic              adc_rd_no,
  output logic              ser_o,
  output logic              frame_start_o
);

  logic [SLOT_W-1:0] slot;
  logic              term;
  logic              rd_done;
  logic [DATA_W-1:0] cap;
  logic [DATA_W-1:0] next_code;
  logic [DATA_W-1:0] frame_code;

  pcm_slot_ctr #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W)
  ) u_slot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .slot_o(slot),
    .term_o(term)
  );

  pcm_conv_ctrl #(
    .DATA_W      (DATA_W),
    .SAMPLE_TICKS(SAMPLE_TICKS),
    .RD_HOLD     (RD_HOLD)
  ) u_conv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .launch_i   (term),
    .done_ni    (adc_done_ni),
    .data_i     (adc_data_i),
    .sample_en_o(sample_en_o),
    .wr_no      (adc_wr_no),
    .rd_no      (adc_rd_no),
    .rd_done_o  (rd_done),
    .cap_o      (cap)
  );

  // read finishing on the boundary bypasses the capture register
  assign next_code = rd_done ? adc_data_i : cap;

  pcm_serializer #(
    .DATA_W     (DATA_W),
    .FRAME_W    (FRAME_W),
    .FRAME_PAT  (FRAME_PAT),
    .INVERT_DATA(INVERT_DATA)
  ) u_ser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slot_i(slot),
    .load_i(term),
    .code_i(next_code),
    .code_o(frame_code),
    .ser_o (ser_o)
  );

  assign frame_start_o = term;

  assert_code_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !term |=> $stable(frame_code));

  assert_boundary_forward_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term && rd_done) |=> (frame_code == $past(adc_data_i)));

  assert_start_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

endmodule

// File: tb/pcm_frame_seq_test.sv
`timescale 1ns/1ps
module pcm_frame_seq_test;

  localparam int TDIV   = 16;
  localparam int RDH    = 2;
  localparam int CO_DLY = 9 * TDIV - 1 - RDH;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] conv_code = 8'h00;
  int         conv_dly = 3;
  logic       adc_done_n = 1'b1;
  logic       sample_en_o, adc_wr_no, adc_rd_no, ser_o, frame_start_o;

  int  conv_cnt = 0;
  bit  conv_armed = 1'b0;
  int  rd_total = 0;
  int  overlap = 0;
  int  n_chk = 0;
  int  n_err = 0;
  bit  done_flag = 1'b0;

  always #10 clk = ~clk;

  pcm_frame_seq uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .adc_data_i   (conv_code),
    .adc_done_ni  (adc_done_n),
    .sample_en_o  (sample_en_o),
    .adc_wr_no    (adc_wr_no),
    .adc_rd_no    (adc_rd_no),
    .ser_o        (ser_o),
    .frame_start_o(frame_start_o)
  );

  // converter model: done falls conv_dly+1 cycles after the write strobe rises
  always @(posedge clk) begin
    if (!adc_wr_no || !adc_rd_no) begin
      adc_done_n <= 1'b1;
      conv_cnt   <= 0;
      conv_armed <= !adc_wr_no;
    end else if (conv_armed) begin
      if (conv_cnt >= conv_dly) begin
        adc_done_n <= 1'b0;
        conv_armed <= 1'b0;
      end else conv_cnt <= conv_cnt + 1;
    end
    if (!adc_rd_no) rd_total <= rd_total + 1;
    if (!adc_rd_no && !adc_wr_no) overlap <= overlap + 1;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [7:0] code, input int s);
    if (s < 8)  return ~code[s];
    if (s == 8) return 1'b1;
    return 1'b0;
  endfunction

  // entered at the negedge of the first cycle of slot 0
  task automatic run_frame(input logic [7:0] shown, input logic [7:0] conv,
                           input int dly, input int exp_rd, input bit coincide,
                           input string tag);
    int rd_base;
    rd_base   = rd_total;
    conv_code = conv;
    conv_dly  = dly;
    chk(tag, ser_o, exp_bit(shown, 0));
    for (int s = 1; s <= 10; s++) begin
      repeat (TDIV - 1) @(negedge clk);
      chk("R1", ser_o, exp_bit(shown, s - 1));
      chk("R1", frame_start_o, 1'b0);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      if (s < 8) chk(tag, ser_o, exp_bit(shown, s));
      else if (s < 10) chk("R3", ser_o, exp_bit(shown, s));
      else begin
        chk("R4", frame_start_o, 1'b1);
        chk("R3", ser_o, 1'b0);
        if (coincide) chk("R8", adc_rd_no, 1'b0);
      end
      if (s == 1) begin
        chk("R5", sample_en_o, 1'b0);
        chk("R5", adc_wr_no, 1'b1);
      end
    end
    @(negedge clk);
    chk("R4", frame_start_o, 1'b0);
    chk("R5", sample_en_o, 1'b1);
    chk("R5", adc_wr_no, 1'b0);
    chk_int("R6", rd_total - rd_base, exp_rd);
  endtask

  initial begin
    logic [7:0] nxt;
    logic [7:0] code;
    repeat (3) @(negedge clk);
    chk("R10", ser_o, 1'b1);
    chk("R10", sample_en_o, 1'b0);
    chk("R10", adc_wr_no, 1'b1);
    chk("R10", adc_rd_no, 1'b1);
    chk("R10", frame_start_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10", ser_o, 1'b1);

    run_frame(8'h00, 8'h80, 3, 0, 1'b0, "R2");       // no launch before first wrap
    run_frame(8'h00, 8'h80, 3, RDH, 1'b0, "R2");
    run_frame(8'h80, 8'h81, 3, RDH, 1'b0, "R2");
    run_frame(8'h81, 8'h5A, CO_DLY, RDH, 1'b1, "R7"); // read ends on terminal cycle
    run_frame(8'h5A, 8'h3C, 1000, 0, 1'b0, "R8");     // handshake abandoned
    run_frame(8'h5A, 8'hFF, 0, RDH, 1'b0, "R9");
    nxt = 8'hFF;
    for (int k = 0; k < 8; k++) begin
      code = 8'(k * 53 + 7);
      run_frame(nxt, code, k, RDH, 1'b0, "R7");
      nxt = code;
    end
    run_frame(nxt, 8'h00, 3, RDH, 1'b0, "R7");
    chk_int("R6", overlap, 0);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule